// File: doc/BRIEF.md
# Device-side DMA request pacer

This block lives on a peripheral that takes data from one DMA channel. It drives an active-low request line to the DMA controller and watches that controller's active-low acknowledge. It never holds the request low as a level. Instead it sends a single-cycle request pulse, and only when the device's receive buffer has room for a whole transfer unit of the configured size.

The pulse scheme matters for small transfer units of 4 bytes or less. With units that small, the controller raises acknowledge in the very cycle it arbitrates. A level request that is dropped in reaction to that acknowledge is still seen as active, so the controller can start a transfer the device has no space for.

The pacer has two states, arming and streaming. In the arming state it waits for the channel to be enabled and for room, then fires the first pulse. In the streaming state each acknowledge either fires the next pulse or sends the block back to arming. Each acknowledge also produces a write strobe toward the device's buffer.

Top module: `dma_req_pacer`

## Requirements
- R1: A synchronous active-high reset forces the arming state. While reset is high, and in the cycle after it, the request line reads 1 (idle) and the write strobe reads 0.
- R2: The request line can only be 0 in a cycle that follows a clock edge at which the channel enable was sampled high.
- R3: The unit size is set by the 2-bit size select: 00 means 1 byte, 01 means 2 bytes, and 10 or 11 mean 4 bytes. In the arming state with the channel enabled, the request goes low for the cycle after the first edge at which the free-byte count is at least one unit. The block then moves to streaming. While the free count is below one unit, no request is issued.
- R4: Every request pulse lasts exactly one clock cycle. An acknowledge sampled while the request is low does not trigger a new pulse and does not change the state.
- R5: In the streaming state, an acknowledge sampled while the request is high, with the free count at least two units, gives a new one-cycle pulse in the next cycle. The block stays in streaming. One unit is set aside for the transfer being acknowledged.
- R6: In the streaming state, an acknowledge sampled while the request is high, with the free count below two units, gives no pulse and returns the block to arming.
- R7: In the streaming state, no pulse is issued without an acknowledge, however much room there is.
- R8: A channel enable sampled low puts the block in the arming state at that edge. The request stays 1 in the following cycle.
- R9: The write strobe is 1 in exactly those cycles that follow an edge at which acknowledge was sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| chan_en | input | 1 | Channel enable |
| free_bytes | input | FREE_W | Free bytes in the device receive buffer |
| xfer_sel | input | 2 | Transfer unit size select |
| ack_n | input | 1 | Controller acknowledge, active low |
| req_n | output | 1 | Request to the controller, active low, registered |
| wr_stb | output | 1 | Write strobe for received data, registered |

## Verification
The hardest case to reach from the ports is an acknowledge that arrives while a request pulse is still low. A well-behaved controller does not do this. The bench therefore forces acknowledge low during a pulse cycle. It then checks that, in the next cycle, the block issues no pulse even though there is ample room, which shows the block stayed in streaming. A second phase runs a controller model that grants one cycle after it sees a request, together with a buffer that drains at random. Across all three unit sizes, it checks that the buffer never overflows and that no pulse is wider than one cycle.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  typedef enum logic {ST_ARM = 1'b0, ST_STRM = 1'b1} pacer_state_e;

  function automatic logic [3:0] unit_bytes(input logic [1:0] sel);
    case (sel)
      2'b00:   unit_bytes = 4'd1;
      2'b01:   unit_bytes = 4'd2;
      default: unit_bytes = 4'd4;
    endcase
  endfunction
endpackage

// File: rtl/pacer_room.sv
module pacer_room #(
  parameter int FREE_W = 12
) (
  input  logic [FREE_W-1:0] free_bytes,
  input  logic [1:0]        xfer_sel,
  output logic              room_one,
  output logic              room_two
);
  localparam int CW = FREE_W + 1;
  logic [CW-1:0] one_u;
  logic [CW-1:0] two_u;
  logic [CW-1:0] free_x;

  assign one_u    = CW'(pacer_pkg::unit_bytes(xfer_sel));
  assign two_u    = one_u << 1;
  assign free_x   = {1'b0, free_bytes};
  assign room_one = free_x >= one_u;
  assign room_two = free_x >= two_u;
endmodule

// File: rtl/pacer_fsm.sv
module pacer_fsm (
  input  logic clk,
  input  logic rst,
  input  logic chan_en,
  input  logic ack_n,
  input  logic room_one,
  input  logic room_two,
  output logic req_n
);
  import pacer_pkg::*;
  pacer_state_e state_q, state_d;
  logic         req_d;

  always_comb begin
    state_d = state_q;
    req_d   = 1'b1;
    if (!chan_en) begin
      state_d = ST_ARM;
    end else begin
      case (state_q)
        ST_ARM: begin
          if (room_one) begin
            req_d   = 1'b0;
            state_d = ST_STRM;
          end
        end
        ST_STRM: begin
          if (!ack_n && req_n) begin
            if (room_two) req_d = 1'b0;
            else          state_d = ST_ARM;
          end
        end
        default: state_d = ST_ARM;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ARM;
      req_n   <= 1'b1;
    end else begin
      state_q <= state_d;
      req_n   <= req_d;
    end
  end
endmodule

// File: rtl/pacer_wstb.sv
module pacer_wstb (
  input  logic clk,
  input  logic rst,
  input  logic ack_n,
  output logic wr_stb
);
  always_ff @(posedge clk) begin
    if (rst) wr_stb <= 1'b0;
    else     wr_stb <= ~ack_n;
  end
endmodule

// File: rtl/dma_req_pacer.sv
module dma_req_pacer #(
  parameter int FREE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chan_en,
  input  logic [FREE_W-1:0] free_bytes,
  input  logic [1:0]        xfer_sel,
  input  logic              ack_n,
  output logic              req_n,
  output logic              wr_stb
);
  logic room_one;
  logic room_two;

  pacer_room #(.FREE_W(FREE_W)) u_room (
    .free_bytes(free_bytes),
    .xfer_sel  (xfer_sel),
    .room_one  (room_one),
    .room_two  (room_two)
  );

  pacer_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .chan_en (chan_en),
    .ack_n   (ack_n),
    .room_one(room_one),
    .room_two(room_two),
    .req_n   (req_n)
  );

  pacer_wstb u_wstb (
    .clk   (clk),
    .rst   (rst),
    .ack_n (ack_n),
    .wr_stb(wr_stb)
  );
endmodule

// File: rtl/dma_req_pacer_chk.sv
module dma_req_pacer_chk #(
  parameter int FREE_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              chan_en,
  input logic [FREE_W-1:0] free_bytes,
  input logic [1:0]        xfer_sel,
  input logic              ack_n,
  input logic              req_n,
  input logic              wr_stb
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  always_ff @(posedge clk) begin
    if (rst_q) begin
      reset_idle_chk: assert (req_n && !wr_stb);
    end
  end

  // R2
  en_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !req_n |-> $past(chan_en));

  // R3
  room_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(req_n) |-> ({1'b0, $past(free_bytes)} >= (FREE_W+1)'(pacer_pkg::unit_bytes($past(xfer_sel)))));

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    !req_n |=> req_n);

  // R8
  disable_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> req_n);

  // R9
  wr_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_n |=> wr_stb);

  // R9
  wr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ack_n |=> !wr_stb);
endmodule

bind dma_req_pacer dma_req_pacer_chk #(.FREE_W(FREE_W)) i_chk (.*);

// File: tb/test_dma_req_pacer.sv
module test_dma_req_pacer;
  localparam int FREE_W = 12;
  localparam int CAP    = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              chan_en = 1'b0;
  logic [FREE_W-1:0] free_bytes = '0;
  logic [1:0]        xfer_sel = 2'b10;
  logic              ack_n = 1'b1;
  logic              req_n;
  logic              wr_stb;

  int n_vec  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct {
    logic  req;
    logic  wr;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  dma_req_pacer #(.FREE_W(FREE_W)) i_dma_req_pacer (
    .clk(clk), .rst(rst), .chan_en(chan_en), .free_bytes(free_bytes),
    .xfer_sel(xfer_sel), .ack_n(ack_n), .req_n(req_n), .wr_stb(wr_stb)
  );

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if (req_n !== e.req || wr_stb !== e.wr) begin
        n_fail++;
        $display("FAIL %s: req_n/wr_stb actual %b/%b expected %b/%b",
                 e.tag, req_n, wr_stb, e.req, e.wr);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected below 100000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  task automatic step(input logic r, input logic en, input int fb, input logic [1:0] sel,
                      input logic ak, input logic ereq, input logic ewr, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; chan_en = en; free_bytes = FREE_W'(fb); xfer_sel = sel; ack_n = ak;
    e.req = ereq; e.wr = ewr; e.tag = tag;
    exp_q.push_back(e);
  endtask

  function automatic int sz_of(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  initial begin
    // scripted phase
    step(1, 1, 100, 2, 1, 1, 0, "R1");
    step(1, 1, 100, 2, 1, 1, 0, "R1");
    step(0, 0, 100, 2, 1, 1, 0, "R2");
    step(0, 1,   3, 2, 1, 1, 0, "R3");
    step(0, 1,   4, 2, 1, 0, 0, "R3");
    step(0, 1,   4, 2, 1, 1, 0, "R4");
    step(0, 1, 100, 2, 1, 1, 0, "R7");
    step(0, 1,   8, 2, 0, 0, 1, "R5");
    step(0, 1,   8, 2, 1, 1, 0, "R4");
    step(0, 1,   7, 2, 0, 1, 1, "R6");
    step(0, 1,   4, 2, 1, 0, 0, "R6");
    step(0, 1,   8, 2, 0, 1, 1, "R4");
    step(0, 1,   8, 2, 1, 1, 0, "R4");
    step(0, 0,   8, 2, 0, 1, 1, "R8");
    step(0, 0,   8, 2, 1, 1, 0, "R8");
    step(0, 1,   8, 2, 1, 0, 0, "R8");
    step(0, 1,   8, 2, 1, 1, 0, "R9");
    step(0, 0,   1, 0, 1, 1, 0, "R8");
    step(0, 1,   1, 0, 1, 0, 0, "R3");
    step(0, 1,   1, 1, 1, 1, 0, "R4");
    step(0, 1,   3, 1, 0, 1, 1, "R6");
    step(0, 1,   1, 1, 1, 1, 0, "R3");
    step(0, 1,   2, 1, 1, 0, 0, "R3");
    step(0, 1,   4, 1, 1, 1, 0, "R4");
    step(0, 1,   4, 1, 0, 0, 1, "R5");
    step(0, 1,   7, 3, 1, 1, 0, "R4");
    step(0, 1,   7, 3, 0, 1, 1, "R6");
    step(0, 1,   4, 3, 1, 0, 0, "R3");
    step(1, 1,   4, 3, 1, 1, 0, "R1");
    step(0, 1,   3, 2, 1, 1, 0, "R1");
    step(0, 0,   0, 2, 1, 1, 0, "R9");
    repeat (3) @(negedge clk);

    // closed-loop phase: controller grants one cycle after it sees a request
    for (int blk = 0; blk < 3; blk++) begin
      int  occ;
      int  sz;
      bit  grant;
      bit  prev_low;
      occ = 0; grant = 1'b0; prev_low = 1'b0;
      sz  = sz_of(2'(blk));
      chan_en = 1'b0; ack_n = 1'b1; xfer_sel = 2'(blk); free_bytes = FREE_W'(CAP);
      repeat (4) @(negedge clk);
      chan_en = 1'b1;
      for (int i = 0; i < 1500; i++) begin
        @(negedge clk);
        if (wr_stb) occ += sz;
        n_vec++;
        if (occ > CAP) begin
          n_fail++;
          $display("FAIL R6: buffer fill actual %0d expected at most %0d", occ, CAP);
        end
        n_vec++;
        if (!req_n && prev_low) begin
          n_fail++;
          $display("FAIL R4: pulse width actual 2+ cycles expected 1");
        end
        prev_low = !req_n;
        ack_n = grant ? 1'b0 : 1'b1;
        grant = !req_n;
        if (occ > 0 && ($urandom % 3) == 0) occ -= 1;
        free_bytes = FREE_W'(CAP - occ);
      end
      @(negedge clk);
      ack_n = 1'b1; chan_en = 1'b0;
      repeat (3) @(negedge clk);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule